// File: doc/BRIEF.md
# Link Health Monitor With Event Counters

This block watches the health of an optical uplink. It samples the lock and error flags of a jitter-cleaning PLL, the lock flags of two on-chip clock managers (one for the trigger clock, one for the transmit clock), the ready flags of three serializers and two clock-stopped flags. It also checks the bunch-crossing framing: it measures the spacing between BC0 orbit markers and compares the bunch-crossing numbers that arrive from the top and bottom data sources. Each clock is one crossing.

The block keeps a live status word and eight saturating event counters. The status word and the counters can be read through a small registered read port. A single clear strobe zeroes all counters and the sticky spacing-error bit. Monitoring software polls the read port. It clears the counters after it has logged them.

Top module: `link_health_mon`

## Requirements
- R1: `status_o` bits 1..9 show the inputs sampled at the previous clock edge: bit1 PLL error, bit2 PLL locked, bits 3/4/5 serializer 0/1/2 ready, bit6 receive clock stopped, bit7 trigger clock stopped, bit8 trigger clock manager locked, bit9 transmit clock manager locked. All of these bits are 0 after reset.
- R2: Every counter is CTR_W bits wide (default 8). A counter that has reached its all-ones value (255) keeps that value until it is cleared.
- R3: No counter goes up by more than one in any clock.
- R4: Counter 0 goes up by one on each clock where either clock manager lock flag falls from 1 to 0. When both fall in the same clock, it still adds only one.
- R5: Counters 1, 2 and 3 count the 1-to-0 transitions of serializer ready 0, 1 and 2.
- R6: Counter 4 counts the 1-to-0 transitions of PLL locked. Counter 5 counts the 0-to-1 transitions of PLL error.
- R7: `clr_i` zeroes all counters and status bit 0 at the next edge. When an event occurs in the same clock, the clear wins.
- R8: The first BC0 after reset only arms the spacing check. Each later BC0 that arrives a number of clocks other than ORBIT_LEN after the previous BC0 adds one to counter 6 and sets status bit 0. Status bit 0 stays set until it is cleared.
- R9: Counter 7 goes up by one on every clock where `bcn_top_i` differs from `bcn_bot_i`.
- R10: `rd_data_o` returns, one clock after `rd_addr_i` is presented, the following values taken before that edge: address 0 gives the status word zero-extended, addresses 1..8 give counters 0..7, and any other address gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bunch crossing per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Clears the counters and the sticky spacing error |
| pll_lock_i | input | 1 | PLL locked flag |
| pll_err_i | input | 1 | PLL error flag |
| tcm_lock_i | input | 1 | Trigger clock manager locked |
| xcm_lock_i | input | 1 | Transmit clock manager locked |
| ser_rdy_i | input | 3 | Serializer ready flags, bit n = serializer n |
| rxclk_stop_i | input | 1 | Receive clock stopped flag |
| tclk_stop_i | input | 1 | Trigger clock stopped flag |
| bc0_i | input | 1 | Orbit marker |
| bcn_top_i | input | BCN_W | Bunch-crossing number, top source |
| bcn_bot_i | input | BCN_W | Bunch-crossing number, bottom source |
| rd_addr_i | input | 4 | Read address |
| rd_data_o | output | 16 | Registered read data |
| status_o | output | 10 | Live status word |

## Verification
The bench builds the block with ORBIT_LEN set to 24 in place of 3564. With this value, correct orbits, early markers, late markers and the arming of the check after a reset all occur many times within a short run. CTR_W keeps its default of 8. Long directed bursts of mismatches and serializer drops therefore drive counters to the 255 ceiling and keep them pressed against it.

// File: rtl/lhm_pkg.sv
package lhm_pkg;

    localparam int NUM_CTR  = 8;
    localparam int NUM_SER  = 3;
    localparam int STAT_W   = 10;
    localparam int SAMP_W   = STAT_W - 1;

    // Counter slots; the read address of slot k is k+1.
    typedef enum logic [2:0] {
        EV_CM_LOSS   = 3'd0,
        EV_SER0_DROP = 3'd1,
        EV_SER1_DROP = 3'd2,
        EV_SER2_DROP = 3'd3,
        EV_PLL_LOSS  = 3'd4,
        EV_PLL_ERR   = 3'd5,
        EV_BC_SPACE  = 3'd6,
        EV_BCN_DIFF  = 3'd7
    } ev_idx_e;

    // Sampled inputs, packed so that {samp, sticky} is the status word.
    typedef struct packed {
        logic                 xcm_lock;
        logic                 tcm_lock;
        logic                 tclk_stop;
        logic                 rxclk_stop;
        logic [NUM_SER-1:0]   ser_rdy;
        logic                 pll_lock;
        logic                 pll_err;
    } samp_t;

endpackage

// File: rtl/lhm_sat_ctr.sv
module lhm_sat_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] CMAX = {W{1'b1}};

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i && (cnt_q != CMAX)) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/lhm_bc_check.sv
module lhm_bc_check #(
    parameter int ORBIT_LEN = 3564
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bc0_i,
    output logic err_o
);
    localparam int BXW = $clog2(ORBIT_LEN + 1) + 1;
    localparam logic [BXW-1:0] BX_MAX  = {BXW{1'b1}};
    localparam logic [BXW-1:0] BX_GOOD = BXW'(ORBIT_LEN);

    typedef struct packed {
        logic           armed;
        logic [BXW-1:0] gap;
    } bc_st_t;

    bc_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        err_o = 1'b0;
        if (bc0_i) begin
            err_o    = st_q.armed && (st_q.gap != BX_GOOD);
            st_d.armed = 1'b1;
            st_d.gap   = BXW'(1);
        end else if (st_q.gap != BX_MAX) begin
            st_d.gap = st_q.gap + BXW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/link_health_mon.sv
module link_health_mon
    import lhm_pkg::*;
#(
    parameter int ORBIT_LEN = 3564,
    parameter int BCN_W     = 12,
    parameter int CTR_W     = 8,
    parameter int ADDR_W    = 4,
    parameter int RD_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              pll_lock_i,
    input  logic              pll_err_i,
    input  logic              tcm_lock_i,
    input  logic              xcm_lock_i,
    input  logic [2:0]        ser_rdy_i,
    input  logic              rxclk_stop_i,
    input  logic              tclk_stop_i,
    input  logic              bc0_i,
    input  logic [BCN_W-1:0]  bcn_top_i,
    input  logic [BCN_W-1:0]  bcn_bot_i,
    input  logic [3:0]        rd_addr_i,
    output logic [15:0]       rd_data_o,
    output logic [9:0]        status_o
);
    typedef struct packed {
        samp_t            samp;
        logic             sticky;
        logic [RD_W-1:0]  rd;
    } mon_st_t;

    mon_st_t st_d, st_q;
    samp_t   samp_now;
    logic [NUM_CTR-1:0]        ev;
    logic [CTR_W-1:0]          ctr [NUM_CTR];
    logic [NUM_CTR*CTR_W-1:0]  ctr_flat;
    logic                      bc_err;
    logic [STAT_W-1:0]         stat_w;

    lhm_bc_check #(.ORBIT_LEN(ORBIT_LEN)) u_bc (
        .clk   (clk),
        .rst_n (rst_n),
        .bc0_i (bc0_i),
        .err_o (bc_err)
    );

    always_comb begin
        samp_now.xcm_lock   = xcm_lock_i;
        samp_now.tcm_lock   = tcm_lock_i;
        samp_now.tclk_stop  = tclk_stop_i;
        samp_now.rxclk_stop = rxclk_stop_i;
        samp_now.ser_rdy    = ser_rdy_i;
        samp_now.pll_lock   = pll_lock_i;
        samp_now.pll_err    = pll_err_i;
    end

    always_comb begin
        ev = '0;
        ev[EV_CM_LOSS]  = (st_q.samp.tcm_lock & ~tcm_lock_i)
                        | (st_q.samp.xcm_lock & ~xcm_lock_i);
        ev[EV_PLL_LOSS] = st_q.samp.pll_lock & ~pll_lock_i;
        ev[EV_PLL_ERR]  = ~st_q.samp.pll_err & pll_err_i;
        ev[EV_BC_SPACE] = bc_err;
        ev[EV_BCN_DIFF] = (bcn_top_i != bcn_bot_i);
        for (int s = 0; s < NUM_SER; s++) begin
            ev[EV_SER0_DROP + s] = st_q.samp.ser_rdy[s] & ~ser_rdy_i[s];
        end
    end

    for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
        lhm_sat_ctr #(.W(CTR_W)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (clr_i),
            .inc_i (ev[k]),
            .cnt_o (ctr[k])
        );
        assign ctr_flat[k*CTR_W +: CTR_W] = ctr[k];
    end

    assign stat_w = {st_q.samp, st_q.sticky};

    always_comb begin
        st_d      = st_q;
        st_d.samp = samp_now;
        if (clr_i)       st_d.sticky = 1'b0;
        else if (bc_err) st_d.sticky = 1'b1;

        st_d.rd = '0;
        if (rd_addr_i == '0) begin
            st_d.rd = RD_W'(stat_w);
        end else if (int'(rd_addr_i) <= NUM_CTR) begin
            st_d.rd = RD_W'(ctr[int'(rd_addr_i) - 1]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o  = stat_w;
    assign rd_data_o = 16'(st_q.rd);
endmodule

// File: rtl/lhm_checker.sv
module lhm_checker #(
    parameter int CTR_W = 8,
    parameter int BCN_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               clr_i,
    input logic               pll_lock_i,
    input logic               tcm_lock_i,
    input logic               xcm_lock_i,
    input logic [BCN_W-1:0]   bcn_top_i,
    input logic [BCN_W-1:0]   bcn_bot_i,
    input logic [9:0]         status_o,
    input logic [8*CTR_W-1:0] ctr_flat
);
    localparam logic [CTR_W-1:0] CMAX = {CTR_W{1'b1}};

    logic [CTR_W-1:0] c [8];
    for (genvar k = 0; k < 8; k++) begin : g_unpack
        assign c[k] = ctr_flat[k*CTR_W +: CTR_W];

        AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i && c[k] == CMAX) |=> (c[k] == CMAX)); // R2

        AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
            !clr_i |=> (c[k] == $past(c[k]) || c[k] == CTR_W'($past(c[k]) + 1'b1))); // R3
    end

    AST_CM_ONE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && c[0] != CMAX && ((status_o[8] && !tcm_lock_i) || (status_o[9] && !xcm_lock_i)))
        |=> (c[0] == CTR_W'($past(c[0]) + 1'b1))); // R4

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (ctr_flat == '0 && !status_o[0])); // R7

    AST_SPACING_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[0] && !clr_i) |=> status_o[0]); // R8

    AST_BCN_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && bcn_top_i != bcn_bot_i && c[7] != CMAX)
        |=> (c[7] == CTR_W'($past(c[7]) + 1'b1))); // R9

    AST_LOCK_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status_o[2] == $past(pll_lock_i))); // R1
endmodule

bind link_health_mon lhm_checker #(.CTR_W(CTR_W), .BCN_W(BCN_W)) u_lhm_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr_i),
    .pll_lock_i (pll_lock_i),
    .tcm_lock_i (tcm_lock_i),
    .xcm_lock_i (xcm_lock_i),
    .bcn_top_i  (bcn_top_i),
    .bcn_bot_i  (bcn_bot_i),
    .status_o   (status_o),
    .ctr_flat   (ctr_flat)
);

// File: tb/test_link_health_mon.sv
module test_link_health_mon;
    localparam int ORBIT = 24;
    localparam int BCN_W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr, pll_lock, pll_err, tcm_lock, xcm_lock, rxs, tcs, bc0;
    logic [2:0] ser;
    logic [BCN_W-1:0] bt, bb;
    logic [3:0] addr;
    logic [15:0] rd_data;
    logic [9:0] status;

    always #2.5 clk = ~clk;

    link_health_mon #(.ORBIT_LEN(ORBIT), .BCN_W(BCN_W)) i_link_health_mon (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .pll_lock_i(pll_lock),
        .pll_err_i(pll_err), .tcm_lock_i(tcm_lock), .xcm_lock_i(xcm_lock),
        .ser_rdy_i(ser), .rxclk_stop_i(rxs), .tclk_stop_i(tcs), .bc0_i(bc0),
        .bcn_top_i(bt), .bcn_bot_i(bb), .rd_addr_i(addr),
        .rd_data_o(rd_data), .status_o(status)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    string tag = "";

    // reference model state
    logic [8:0] m_prev;
    int m_ctr [8];
    bit m_sticky, m_armed;
    int m_gap;
    logic [15:0] m_rd;

    function automatic logic [8:0] pack_in();
        return {xcm_lock, tcm_lock, tcs, rxs, ser, pll_lock, pll_err};
    endfunction

    function automatic logic [9:0] m_status();
        return {m_prev, m_sticky};
    endfunction

    function automatic string ctr_tag(int a);
        if (tag != "") return tag;
        case (a)
            0: return "R1/R8/R10";
            1: return "R4";
            2, 3, 4: return "R5";
            5, 6: return "R6";
            7: return "R8";
            8: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic cmp(string what, int act, int exp, string t);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", t, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_prev = '0; m_sticky = 0; m_armed = 0; m_gap = 0; m_rd = '0;
        for (int k = 0; k < 8; k++) m_ctr[k] = 0;
    endtask

    task automatic model_edge();
        logic [8:0] cur = pack_in();
        bit ev [8];
        bit berr = 0;
        if (addr == 0) m_rd = 16'(m_status());
        else if (addr <= 8) m_rd = 16'(m_ctr[addr-1]);
        else m_rd = '0;
        ev[0] = (m_prev[7] && !cur[7]) || (m_prev[8] && !cur[8]);
        ev[1] = m_prev[2] && !cur[2];
        ev[2] = m_prev[3] && !cur[3];
        ev[3] = m_prev[4] && !cur[4];
        ev[4] = m_prev[1] && !cur[1];
        ev[5] = !m_prev[0] && cur[0];
        if (bc0) begin
            berr = m_armed && (m_gap != ORBIT);
            m_armed = 1; m_gap = 1;
        end else m_gap++;
        ev[6] = berr;
        ev[7] = (bt != bb);
        for (int k = 0; k < 8; k++) begin
            if (clr) m_ctr[k] = 0;
            else if (ev[k] && m_ctr[k] < 255) m_ctr[k]++;
        end
        if (clr) m_sticky = 0; else if (berr) m_sticky = 1;
        m_prev = cur;
    endtask

    // one clock: model follows the edge, outputs compared at the negedge
    task automatic tick();
        logic [3:0] a = addr;
        model_edge();
        @(posedge clk);
        @(negedge clk);
        cmp("status", int'(status), int'(m_status()), "R1/R8");
        cmp($sformatf("rd[%0d]", a), int'(rd_data), int'(m_rd), ctr_tag(a));
    endtask

    task automatic idle_inputs();
        clr = 0; pll_lock = 1; pll_err = 0; tcm_lock = 1; xcm_lock = 1;
        ser = 3'b111; rxs = 0; tcs = 0; bc0 = 0; bt = '0; bb = '0; addr = '0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        model_reset();
        repeat (3) @(negedge clk);
        cmp("reset status", int'(status), 0, "R1");
        cmp("reset rd", int'(rd_data), 0, "R10");
        rst_n = 1;
    endtask

    task automatic read_all(string t);
        tag = t;
        for (int a = 0; a < 10; a++) begin addr = 4'(a); tick(); end
        tick();
        tag = "";
    endtask

    int gap_bench;

    initial begin
        void'($urandom(32'd20240607));
        idle_inputs();
        @(negedge clk);
        do_reset();

        // R4 / R3: both clock managers drop in one clock -> single count
        tag = "R3/R4";
        tick();
        tcm_lock = 0; xcm_lock = 0; addr = 4'd1; tick();
        tick(); tick();
        tcm_lock = 1; xcm_lock = 1; tick();
        tag = "";

        // R5 / R6 directed drops
        ser = 3'b010; tick();
        pll_lock = 0; pll_err = 1; tick();
        ser = 3'b111; pll_lock = 1; pll_err = 0; tick();
        read_all("R5/R6");

        // R8: first marker only arms, exact spacing passes, off by one fails
        do_reset();
        tag = "R8";
        repeat (5) tick();
        bc0 = 1; tick(); bc0 = 0;
        repeat (ORBIT - 1) tick();
        bc0 = 1; tick(); bc0 = 0;
        repeat (ORBIT) tick();
        bc0 = 1; addr = 4'd7; tick(); bc0 = 0;
        repeat (3) tick();
        tag = "";
        read_all("R8");

        // R7: clear while a mismatch and a drop hit in the same clock
        tag = "R7";
        bt = 12'd5; bb = 12'd6; ser[1] = 0; clr = 1; addr = 4'd8; tick();
        clr = 0; bt = '0; bb = '0; ser[1] = 1; tick(); tick();
        tag = "";
        read_all("R7");

        // R2: saturate counters 1 and 7, then keep pushing
        tag = "R2";
        addr = 4'd8;
        for (int i = 0; i < 600; i++) begin
            bt = 12'(i); bb = 12'(i + 1);
            ser[0] = i[0];
            addr = i[1] ? 4'd8 : 4'd2;
            tick();
        end
        bt = '0; bb = '0; ser = 3'b111;
        tag = "";
        read_all("R2");

        // random mix (R1, R3..R10)
        gap_bench = 0;
        for (int i = 0; i < 6000; i++) begin
            if ($urandom % 16 == 0) pll_lock = ~pll_lock;
            if ($urandom % 32 == 0) pll_err  = ~pll_err;
            if ($urandom % 16 == 0) tcm_lock = ~tcm_lock;
            if ($urandom % 16 == 0) xcm_lock = ~xcm_lock;
            if ($urandom % 8 == 0)  ser = ser ^ 3'($urandom % 8);
            if ($urandom % 32 == 0) rxs = ~rxs;
            if ($urandom % 32 == 0) tcs = ~tcs;
            gap_bench++;
            bc0 = ((gap_bench >= ORBIT) && ($urandom % 8 != 0)) || ($urandom % 97 == 0);
            if (bc0) gap_bench = 0;
            bt = 12'(i);
            bb = ($urandom % 16 == 0) ? 12'(i ^ 1) : 12'(i);
            clr = ($urandom % 400 == 0);
            addr = 4'($urandom % 12);
            if (i == 3000) begin
                rst_n = 0; model_reset();
                @(negedge clk);
                rst_n = 1;
            end
            tick();
        end
        idle_inputs();
        read_all("R10");

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule